// File: doc/BRIEF.md
# Hiccup Overcurrent Retry Sequencer

This block sequences start-up and overcurrent recovery for a synchronous buck regulator. Once the supply-ready enable is high, it raises a digital reference code in equal steps from zero to full scale. The code feeds the regulator's error amplifier. The block enables the output stage for the whole ramp and for normal operation after the ramp. A synchronized overcurrent comparator flag is watched throughout the ramp and in normal operation.

On a trip the output stage is switched off on the next clock edge and the reference returns to zero. The block then waits out two dummy timeouts, each as long as a full soft-start. After that it tries a fresh ramp. If the fault is still present, that ramp is cut short and the cycle repeats. The retry period is therefore two interval lengths plus whatever part of the real ramp ran before the trip. Starting up into a shorted load follows exactly the same path. Dropping the enable returns the block to idle from any state.

Top module: `hiccup_seq`

## Requirements
- R1: Under reset, and in idle while the supply-ready enable is low, the reference code is 0 and the output enable, hiccup and running flags are all 0. The overcurrent flag has no effect in idle.
- R2: In the first cycle after the enable is seen high in idle, the output enable is 1 and the reference code is 0.
- R3: During the ramp the code rises by exactly one every STEP_CYC cycles, from 0 to all ones. The whole ramp lasts SS_CYCLES = STEP_CYC * 2^CODE_W cycles. After the ramp, running is 1 and the code stays at all ones.
- R4: The overcurrent flag passes through a two-flop synchronizer. A flag raised before a clock edge leaves the output enabled for two more cycles and removes it after the third edge.
- R5: A trip during the ramp aborts it. The output enable drops to 0, the code drops to 0 and hiccup rises to 1.
- R6: Hiccup lasts exactly 2 * SS_CYCLES cycles, made of two dummy timeouts. Throughout, the code is 0, the output enable is 0, running is 0, and the overcurrent flag is ignored.
- R7: After the second dummy timeout a new ramp starts from code 0. If the synchronized flag is still high, the ramp lasts exactly one cycle and hiccup restarts. If the flag is clear, the ramp runs to completion.
- R8: A trip while running causes the same shutoff and two-timeout recovery as a trip during the ramp.
- R9: Enabling into a persistent overcurrent gives one ramp cycle followed by the same hiccup sequence as a retry.
- R10: When the enable goes low, the block returns to idle on the next edge from any state. Raising the enable again starts a fresh ramp from code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Supply-ready enable |
| oc_flag | input | 1 | Overcurrent comparator flag, asynchronous |
| ref_code | output | CODE_W | Soft-start reference code |
| out_en | output | 1 | Output stage enable |
| hiccup | output | 1 | High during the dummy timeouts |
| running | output | 1 | High in normal operation after the ramp |

## Verification
A wrong state or a miscounted timer shows at the ports within one cycle of the first divergence. The four outputs are compared every cycle against an expected timeline. A state held one cycle too long or too short therefore moves the rising edge of the output enable, the edge of running, or a single code step. A synchronizer stage that is missing or added shifts the shutoff edge by one cycle relative to the flag.

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 2125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              oc_flag,
  output logic [CODE_W-1:0] ref_code,
  output logic              out_en,
  output logic              hiccup,
  output logic              running
);
  localparam int SS_CYCLES = STEP_CYC * (2 ** CODE_W);
  localparam int TW = $clog2(SS_CYCLES);
  localparam logic [TW-1:0] SS_LAST   = TW'(SS_CYCLES - 1);
  localparam logic [TW-1:0] STEP_LAST = TW'(STEP_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_DUMMY1, S_DUMMY2, S_RAMP, S_RUN} st_t;

  st_t st;
  logic oc_s1, oc_s2;
  logic [TW-1:0] tmr;
  logic [CODE_W-1:0] code;

  wire trip     = oc_s2 && (st == S_RAMP || st == S_RUN);
  wire tmr_end  = (tmr == SS_LAST);
  wire step_end = (tmr == STEP_LAST);
  wire at_top   = &code;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_s1 <= 1'b0;
      oc_s2 <= 1'b0;
      st    <= S_IDLE;
      tmr   <= '0;
      code  <= '0;
    end else begin
      oc_s1 <= oc_flag;
      oc_s2 <= oc_s1;
      if (!supply_ok) begin
        st   <= S_IDLE;
        tmr  <= '0;
        code <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            st   <= S_RAMP;
            tmr  <= '0;
            code <= '0;
          end
          S_DUMMY1: begin
            if (tmr_end) begin
              st  <= S_DUMMY2;
              tmr <= '0;
            end else tmr <= tmr + 1'b1;
          end
          S_DUMMY2: begin
            if (tmr_end) begin
              st   <= S_RAMP;
              tmr  <= '0;
              code <= '0;
            end else tmr <= tmr + 1'b1;
          end
          S_RAMP: begin
            if (trip) begin
              st   <= S_DUMMY1;
              tmr  <= '0;
              code <= '0;
            end else if (step_end) begin
              tmr <= '0;
              if (at_top) st <= S_RUN;
              else code <= code + 1'b1;
            end else tmr <= tmr + 1'b1;
          end
          S_RUN: begin
            if (trip) begin
              st   <= S_DUMMY1;
              tmr  <= '0;
              code <= '0;
            end
          end
          default: begin
            st   <= S_IDLE;
            tmr  <= '0;
            code <= '0;
          end
        endcase
      end
    end
  end

  assign ref_code = code;
  assign out_en   = (st == S_RAMP) || (st == S_RUN);
  assign hiccup   = (st == S_DUMMY1) || (st == S_DUMMY2);
  assign running  = (st == S_RUN);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (ref_code == '0 && !out_en && !hiccup && !running));

  p_trip_kills_r5: assert property (@(posedge clk) disable iff (rst)
    (out_en && oc_s2 && supply_ok) |=> (!out_en && hiccup && ref_code == '0));

  p_hiccup_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    hiccup |-> (ref_code == '0 && !out_en && !running));

  p_dummy_bound_r6: assert property (@(posedge clk) disable iff (rst)
    hiccup |-> (tmr <= SS_LAST));

  p_code_step_r3: assert property (@(posedge clk) disable iff (rst)
    (out_en && !running) |=> (!out_en || ref_code == $past(ref_code) ||
                              ref_code == $past(ref_code) + 1'b1));

  p_run_full_r3: assert property (@(posedge clk) disable iff (rst)
    running |-> (&ref_code && out_en));

  p_ramp_from_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> (ref_code == '0 && !running));
endmodule

// File: tb/hiccup_seq_test.sv
module hiccup_seq_test;
  localparam int P    = 10;
  localparam int CW   = 3;
  localparam int STEP = 4;
  localparam int SS   = STEP * (2 ** CW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic oc_flag = 1'b0;
  logic [CW-1:0] ref_code;
  logic out_en, hiccup, running;

  int checks = 0;
  int fails  = 0;

  logic [CW+2:0] exp_q[$];
  string tag_q[$];

  always #(P/2) clk = ~clk;

  hiccup_seq #(.CODE_W(CW), .STEP_CYC(STEP)) uut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .oc_flag(oc_flag),
    .ref_code(ref_code), .out_en(out_en), .hiccup(hiccup), .running(running)
  );

  task automatic push(input int n, input int code, input logic en,
                      input logic hic, input logic run, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({CW'(code), en, hic, run});
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_ramp(input int lo, input int hi, input string tag);
    for (int i = lo; i < hi; i++) begin
      exp_q.push_back({CW'(i / STEP), 1'b1, 1'b0, 1'b0});
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(P/4);
      if (exp_q.size() > 0) begin
        logic [CW+2:0] e;
        logic [CW+2:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {ref_code, out_en, hiccup, running};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s t=%0t actual code=%0d en=%b hic=%b run=%b expected code=%0d en=%b hic=%b run=%b",
                   t, $time, a[CW+2:3], a[2], a[1], a[0], e[CW+2:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #(P * 150000);
    fails++;
    $display("FAIL watchdog expired, actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    #(P/4);
    checks++;
    if ({ref_code, out_en, hiccup, running} !== '0) begin
      fails++;
      $display("FAIL R1 reset actual %b expected 0", {ref_code, out_en, hiccup, running});
    end
    rst = 1'b0;
    @(negedge clk);
    push(3, 0, 0, 0, 0, "R1"); wait_n(3);

    // R2 / R3: clean start-up and full ramp
    supply_ok = 1'b1;
    push_ramp(0, 1, "R2");
    push_ramp(1, SS, "R3");
    push(5, (2 ** CW) - 1, 1, 0, 1, "R3");
    wait_n(SS + 5);

    // R4 / R8 / R6 / R7: trip in run, persistent fault
    oc_flag = 1'b1;
    push(2, (2 ** CW) - 1, 1, 0, 1, "R4");
    push(SS, 0, 0, 1, 0, "R8");
    push(SS, 0, 0, 1, 0, "R6");
    push_ramp(0, 1, "R7");
    push(SS, 0, 0, 1, 0, "R7");
    wait_n(2 + 2 * SS + 1 + SS);

    // fault clears during second dummy; R5 trip mid-ramp
    oc_flag = 1'b0;
    push(SS, 0, 0, 1, 0, "R6");
    push_ramp(0, 10, "R5");
    wait_n(SS + 10);
    oc_flag = 1'b1;
    push_ramp(10, 12, "R5");
    push(2 * SS, 0, 0, 1, 0, "R5");
    wait_n(2 + SS);
    oc_flag = 1'b0;
    wait_n(SS);
    push_ramp(0, SS, "R7");
    push(4, (2 ** CW) - 1, 1, 0, 1, "R7");
    wait_n(SS + 4);

    // R10: drop enable while running
    supply_ok = 1'b0;
    push(3, 0, 0, 0, 0, "R10"); wait_n(3);

    // R1 / R9: fault in idle ignored, then enable into a short
    oc_flag = 1'b1;
    push(3, 0, 0, 0, 0, "R1"); wait_n(3);
    supply_ok = 1'b1;
    push_ramp(0, 1, "R9");
    push(2 * SS, 0, 0, 1, 0, "R9");
    push_ramp(0, 1, "R9");
    push(3, 0, 0, 1, 0, "R9");
    wait_n(2 * SS + 5);

    // R10: drop enable during hiccup, then fresh start
    supply_ok = 1'b0;
    oc_flag = 1'b0;
    push(3, 0, 0, 0, 0, "R10"); wait_n(3);
    supply_ok = 1'b1;
    push_ramp(0, SS, "R10");
    push(2, (2 ** CW) - 1, 1, 0, 1, "R10");
    wait_n(SS + 2);

    wait_n(2);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule